// File: doc/BRIEF.md
# 8-bit Arithmetic Logic Unit with Carry and Overflow Flags

This block is the combinational arithmetic logic unit of a small accumulator-style processor. Each instruction supplies a 4-bit operation code, two 8-bit register operands and the two raw 4-bit source fields of the instruction word. From these the unit returns an 8-bit result together with a carry flag and a signed-overflow flag. The surrounding processor latches the result into its working register during the execute step.

Add, subtract, multiply and divide use the language's built-in integer operators. The remaining operations are bitwise. For the immediate operations, the instruction fields supply an operand value directly, and the register operand is not used. A load-immediate forms its result by joining the two fields, with the first field as the upper half. Both flags are held at zero whenever the operation is not arithmetic.

Inside the unit, a decoder turns the operation code into a small control record. A datapath then selects the operands, computes every candidate result and picks one of them.

Top module: `alu8_core`

## Requirements
- R1: Opcode 1 (add) returns (A+B) mod 256. Carry is bit 8 of the 9-bit sum. Overflow is 1 exactly when A[7] equals B[7] and result[7] differs from A[7].
- R2: Opcode 2 (subtract) returns (A-B) mod 256. Carry is 1 when A is below B as unsigned numbers (a borrow). Overflow is 1 exactly when A[7] differs from B[7] and result[7] differs from A[7].
- R3: Opcode 3 (multiply) returns the low 8 bits of the unsigned 16-bit product A*B. Carry is 1 when the upper 8 bits of that product are not all zero. Overflow is 0.
- R4: Opcode 4 (divide) returns the unsigned quotient A/B, with carry 0 and overflow 0. When B is 0, the result is 8'hFF, overflow is 1 and carry is 0.
- R5: Opcodes 5, 6 and 7 return the bitwise AND, OR and XOR of A and B. Opcode 8 returns the bitwise inversion of A.
- R6: For every non-arithmetic opcode (0, 5, 6, 7, 8, 9, 12, 13, 14, 15), carry and overflow are both 0.
- R7: Opcode 9 (load immediate) returns {RA field, RB field}, with the RA field in bits 7:4. The values on A and B have no effect.
- R8: Opcodes 10 and 11 add and subtract the RB field, zero-extended to 8 bits, to and from A. Their result and flags follow R1 and R2 with that value in place of B. The value on B has no effect.
- R9: Opcode 0 and opcodes 13 to 15 return 0. Opcode 12 returns A unchanged.
- R10: The unit holds no state. Its outputs depend only on the present inputs and settle without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 4 | Operation code |
| aVal | input | 8 | First register operand |
| bVal | input | 8 | Second register operand |
| raFld | input | 4 | Raw first source field of the instruction |
| rbFld | input | 4 | Raw second source field of the instruction |
| result | output | 8 | Operation result |
| carryOut | output | 1 | Carry, borrow or product-high flag |
| overflow | output | 1 | Signed overflow or divide-by-zero flag |

## Verification
The embedded checks are immediate assertions, and they assume that every input carries a known 0 or 1. Each check is skipped while any operand, field or opcode is unknown. The bench therefore drives every input to a defined value before its first comparison and never releases an input to X or Z. It changes inputs only on the falling clock edge and compares on the rising edge, so the combinational outputs have half a period to settle. The stimulus covers all sixteen opcodes, carry and overflow boundary values, division by zero, and immediate operations driven with varying B values.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DATA_W = 8;
  localparam int FLD_W  = 4;
  localparam int OPC_W  = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_MUL  = 4'd3,
    OP_DIV  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_NOTA = 4'd8,
    OP_LDI  = 4'd9,
    OP_ADDI = 4'd10,
    OP_SUBI = 4'd11,
    OP_MOV  = 4'd12,
    OP_R13  = 4'd13,
    OP_R14  = 4'd14,
    OP_R15  = 4'd15
  } opcode_e;

  typedef enum logic [3:0] {
    K_ZERO, K_ADD, K_SUB, K_MUL, K_DIV,
    K_AND, K_OR, K_XOR, K_NOT, K_PASS, K_CAT
  } kind_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    kind_e kind;   // which candidate result is selected
    logic  immB;   // second operand taken from the RB field
    logic  arith;  // flags may be nonzero
  } alu_ctrl_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
#(
  parameter int OPC_W_P = OPC_W
) (
  input  logic [OPC_W_P-1:0] opcode,
  output alu_ctrl_t          ctrl
);

  always_comb begin
    ctrl       = '{kind: K_ZERO, immB: 1'b0, arith: 1'b0};
    case (opcode_e'(opcode))
      OP_ADD:  ctrl = '{kind: K_ADD,  immB: 1'b0, arith: 1'b1};
      OP_SUB:  ctrl = '{kind: K_SUB,  immB: 1'b0, arith: 1'b1};
      OP_MUL:  ctrl = '{kind: K_MUL,  immB: 1'b0, arith: 1'b1};
      OP_DIV:  ctrl = '{kind: K_DIV,  immB: 1'b0, arith: 1'b1};
      OP_AND:  ctrl.kind = K_AND;
      OP_OR:   ctrl.kind = K_OR;
      OP_XOR:  ctrl.kind = K_XOR;
      OP_NOTA: ctrl.kind = K_NOT;
      OP_LDI:  ctrl.kind = K_CAT;
      OP_ADDI: ctrl = '{kind: K_ADD,  immB: 1'b1, arith: 1'b1};
      OP_SUBI: ctrl = '{kind: K_SUB,  immB: 1'b1, arith: 1'b1};
      OP_MOV:  ctrl.kind = K_PASS;
      default: ctrl.kind = K_ZERO;
    endcase
  end

  // Decoder sanity: only arithmetic kinds may raise flags
  always_comb begin
    if (!$isunknown(opcode)) begin
      AST_IMM_IS_ARITH: assert (!ctrl.immB || ctrl.arith); // R8
      AST_LOGIC_NO_FLAGS: assert (!(ctrl.kind inside {K_AND, K_OR, K_XOR, K_NOT, K_CAT, K_PASS, K_ZERO}) || !ctrl.arith); // R6
    end
  end

endmodule

// File: rtl/alu8_dp.sv
module alu8_dp
  import alu8_pkg::*;
#(
  parameter int DATA_W_P = DATA_W,
  parameter int FLD_W_P  = FLD_W
) (
  input  alu_ctrl_t             ctrl,
  input  logic [DATA_W_P-1:0]   aVal,
  input  logic [DATA_W_P-1:0]   bVal,
  input  logic [FLD_W_P-1:0]    raFld,
  input  logic [FLD_W_P-1:0]    rbFld,
  output logic [DATA_W_P-1:0]   result,
  output logic                  carryOut,
  output logic                  overflow
);

  localparam int PROD_W = 2 * DATA_W_P;
  localparam int SIGN   = DATA_W_P - 1;
  localparam int PAD_W  = DATA_W_P - FLD_W_P;

  logic [DATA_W_P-1:0] opB;
  logic [DATA_W_P:0]   sumW;
  logic [DATA_W_P:0]   diffW;
  logic [PROD_W-1:0]   prodW;
  logic [DATA_W_P-1:0] quot;
  logic                divZero;
  logic                addOvf;
  logic                subOvf;

  // Operand selection and candidate results
  always_comb begin
    opB     = ctrl.immB ? {{PAD_W{1'b0}}, rbFld} : bVal;
    sumW    = {1'b0, aVal} + {1'b0, opB};
    diffW   = {1'b0, aVal} - {1'b0, opB};
    prodW   = PROD_W'(aVal) * PROD_W'(opB);
    divZero = (opB == '0);
    quot    = divZero ? '1 : (aVal / opB);
    addOvf  = (aVal[SIGN] == opB[SIGN]) && (sumW[SIGN] != aVal[SIGN]);
    subOvf  = (aVal[SIGN] != opB[SIGN]) && (diffW[SIGN] != aVal[SIGN]);
  end

  // Result and flag selection
  always_comb begin
    result   = '0;
    carryOut = 1'b0;
    overflow = 1'b0;
    case (ctrl.kind)
      K_ADD: begin
        result   = sumW[DATA_W_P-1:0];
        carryOut = sumW[DATA_W_P];
        overflow = addOvf;
      end
      K_SUB: begin
        result   = diffW[DATA_W_P-1:0];
        carryOut = diffW[DATA_W_P];
        overflow = subOvf;
      end
      K_MUL: begin
        result   = prodW[DATA_W_P-1:0];
        carryOut = |prodW[PROD_W-1:DATA_W_P];
      end
      K_DIV: begin
        result   = quot;
        overflow = divZero;
      end
      K_AND:   result = aVal & bVal;
      K_OR:    result = aVal | bVal;
      K_XOR:   result = aVal ^ bVal;
      K_NOT:   result = ~aVal;
      K_PASS:  result = aVal;
      K_CAT:   result = DATA_W_P'({raFld, rbFld});
      default: result = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({ctrl, aVal, bVal, raFld, rbFld})) begin
      AST_NONARITH_FLAGS: assert (ctrl.arith || (!carryOut && !overflow)); // R6
      AST_ADD_INVERSE: assert (ctrl.kind != K_ADD || DATA_W_P'(result - opB) == aVal); // R1
      AST_SUB_INVERSE: assert (ctrl.kind != K_SUB || DATA_W_P'(result + opB) == aVal); // R2
      AST_DIV_BY_ZERO: assert (ctrl.kind != K_DIV || opB != '0 || (&result && overflow && !carryOut)); // R4
      AST_DIV_BOUND: assert (ctrl.kind != K_DIV || opB == '0 || (result <= aVal && !overflow)); // R4
    end
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W_P = DATA_W,
  parameter int FLD_W_P  = FLD_W
) (
  input  logic [3:0]          opcode,
  input  logic [DATA_W_P-1:0] aVal,
  input  logic [DATA_W_P-1:0] bVal,
  input  logic [FLD_W_P-1:0]  raFld,
  input  logic [FLD_W_P-1:0]  rbFld,
  output logic [DATA_W_P-1:0] result,
  output logic                carryOut,
  output logic                overflow
);

  alu_ctrl_t ctrl;

  alu8_ctrl #(.OPC_W_P(4)) u_ctrl (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  alu8_dp #(.DATA_W_P(DATA_W_P), .FLD_W_P(FLD_W_P)) u_dp (
    .ctrl     (ctrl),
    .aVal     (aVal),
    .bVal     (bVal),
    .raFld    (raFld),
    .rbFld    (rbFld),
    .result   (result),
    .carryOut (carryOut),
    .overflow (overflow)
  );

  always_comb begin
    if (!$isunknown({opcode, raFld, rbFld})) begin
      AST_LDI_CONCAT: assert (opcode != 4'd9 || result == DATA_W_P'({raFld, rbFld})); // R7
      AST_RESERVED_ZERO: assert (opcode < 4'd13 || (result == '0 && !carryOut && !overflow)); // R9
    end
  end

endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  typedef struct {
    logic [7:0] res;
    logic       c;
    logic       o;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic [3:0] opcode = '0;
  logic [7:0] aVal = '0, bVal = '0;
  logic [3:0] raFld = '0, rbFld = '0;
  logic [7:0] result;
  logic       carryOut, overflow;

  int nCompared = 0;
  int nBad = 0;
  bit finished = 0;
  exp_t scoreQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core dut (
    .opcode(opcode), .aVal(aVal), .bVal(bVal), .raFld(raFld), .rbFld(rbFld),
    .result(result), .carryOut(carryOut), .overflow(overflow)
  );

  function automatic exp_t model(input logic [3:0] op, input logic [7:0] a, b,
                                 input logic [3:0] ra, rb);
    exp_t e;
    int ai, bi, r;
    e.res = 8'h00; e.c = 1'b0; e.o = 1'b0;
    ai = int'(a); bi = int'(b);
    if (op == 4'd10 || op == 4'd11) bi = int'(rb);
    case (op)
      4'd1, 4'd10: begin
        r = ai + bi;
        e.res = r[7:0]; e.c = (r > 255);
        e.o = (ai >= 128) == (bi >= 128) && (e.res[7] != (ai >= 128));
      end
      4'd2, 4'd11: begin
        r = ai - bi;
        e.res = r[7:0]; e.c = (ai < bi);
        e.o = (ai >= 128) != (bi >= 128) && (e.res[7] != (ai >= 128));
      end
      4'd3: begin r = ai * bi; e.res = r[7:0]; e.c = (r > 255); end
      4'd4: if (bi == 0) begin e.res = 8'hFF; e.o = 1'b1; end
            else begin r = ai / bi; e.res = r[7:0]; end
      4'd5: e.res = a & b;
      4'd6: e.res = a | b;
      4'd7: e.res = a ^ b;
      4'd8: e.res = ~a;
      4'd9: e.res = {ra, rb};
      4'd12: e.res = a;
      default: e.res = 8'h00;
    endcase
    case (op)
      4'd1: e.tag = "R1"; 4'd2: e.tag = "R2"; 4'd3: e.tag = "R3"; 4'd4: e.tag = "R4";
      4'd5, 4'd6, 4'd7, 4'd8: e.tag = "R5 R6";
      4'd9: e.tag = "R7 R6"; 4'd10, 4'd11: e.tag = "R8";
      default: e.tag = "R9 R6";
    endcase
    return e;
  endfunction

  // Driver: inputs change on the falling edge, expectation queued
  task automatic drive(input logic [3:0] op, input logic [7:0] a, b,
                       input logic [3:0] ra, rb);
    @(negedge clk);
    opcode = op; aVal = a; bVal = b; raFld = ra; rbFld = rb;
    scoreQ.push_back(model(op, a, b, ra, rb));
  endtask

  // Monitor: compares on the rising edge; no clock reaches the DUT (R10)
  always @(posedge clk) begin
    if (scoreQ.size() > 0) begin
      exp_t e;
      e = scoreQ.pop_front();
      nCompared++;
      if (result !== e.res || carryOut !== e.c || overflow !== e.o) begin
        nBad++;
        $display("FAIL %s R10 op=%0d a=%h b=%h ra=%h rb=%h: got res=%h c=%b o=%b expected res=%h c=%b o=%b",
                 e.tag, opcode, aVal, bVal, raFld, rbFld, result, carryOut, overflow, e.res, e.c, e.o);
      end
    end
  end

  initial begin
    // Initial all-zero state (NOP), R9
    drive(4'd0, 8'h00, 8'h00, 4'h0, 4'h0);
    // R1 boundaries
    drive(4'd1, 8'h7F, 8'h01, 4'h0, 4'h0);
    drive(4'd1, 8'hFF, 8'h01, 4'h0, 4'h0);
    drive(4'd1, 8'h80, 8'h80, 4'h0, 4'h0);
    drive(4'd1, 8'h12, 8'h34, 4'h0, 4'h0);
    // R2 boundaries
    drive(4'd2, 8'h00, 8'h01, 4'h0, 4'h0);
    drive(4'd2, 8'h80, 8'h01, 4'h0, 4'h0);
    drive(4'd2, 8'h7F, 8'hFF, 4'h0, 4'h0);
    drive(4'd2, 8'h50, 8'h50, 4'h0, 4'h0);
    // R3
    drive(4'd3, 8'h10, 8'h10, 4'h0, 4'h0);
    drive(4'd3, 8'h0F, 8'h11, 4'h0, 4'h0);
    // R4 including divide by zero
    drive(4'd4, 8'hC8, 8'h07, 4'h0, 4'h0);
    drive(4'd4, 8'h33, 8'h00, 4'h0, 4'h0);
    drive(4'd4, 8'h05, 8'h09, 4'h0, 4'h0);
    // R5 R6
    drive(4'd5, 8'hF0, 8'h3C, 4'h0, 4'h0);
    drive(4'd6, 8'hF0, 8'h3C, 4'h0, 4'h0);
    drive(4'd7, 8'hFF, 8'hFF, 4'h0, 4'h0);
    drive(4'd8, 8'hA5, 8'hFF, 4'h0, 4'h0);
    // R7: B and A values do not matter
    drive(4'd9, 8'hFF, 8'hFF, 4'hA, 4'h5);
    drive(4'd9, 8'h00, 8'h11, 4'h3, 4'hC);
    // R8: B ignored, RB zero-extended
    drive(4'd10, 8'hFE, 8'h00, 4'h7, 4'h3);
    drive(4'd10, 8'h7C, 8'hFF, 4'h0, 4'h4);
    drive(4'd11, 8'h02, 8'h01, 4'h0, 4'h5);
    drive(4'd11, 8'h80, 8'h80, 4'h9, 4'h1);
    // R9
    drive(4'd12, 8'h5A, 8'hC3, 4'h1, 4'h2);
    drive(4'd13, 8'hFF, 8'hFF, 4'hF, 4'hF);
    drive(4'd14, 8'h80, 8'h80, 4'h8, 4'h8);
    drive(4'd15, 8'h7F, 8'h01, 4'h1, 4'h1);
    // Mixed patterns over every opcode
    for (int i = 0; i < 2000; i++)
      drive(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom),
            4'($urandom), 4'($urandom));
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nBad);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!finished) begin
      nBad++;
      nCompared++;
      $display("FAIL watchdog R10: got no completion, expected completion within %0d cycles", MAX_CYCLES);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nBad);
      $finish;
    end
  end

endmodule